// File: doc/BRIEF.md
# Software Trap Entry and Return Sequencer

This block carries out the memory side of software traps for a 32-bit core. When a trap is started, it saves the status word and then the return address on the system stack, growing the stack downward. It then clears the status flags that the trap variant calls for and loads the new program counter from a handler table that sits relative to a table-base register. When a return is started, it does the reverse: it pops the program counter, then the status word, and releases the eight bytes that entry used.

The decoder supplies the operation, the 8-bit trap number and a snapshot of PC, PS, the system stack pointer and the table base, then pulses start for one cycle. The block runs the memory accesses one at a time over a single word port with request and acknowledge. It presents the resulting PC, PS and stack pointer when it pulses done. The number of cycles depends only on how quickly the memory acknowledges.

Top module: `trap_seq`

## Requirements
- R1: For a numbered trap (op 2'b00) or an emulator trap (op 2'b01), the first access writes PS to SSP-4 and the second writes PC+2 to SSP-8. Writes have mem_we_o = 1.
- R2: A numbered trap clears PS bit 5 (S) and bit 4 (I) and leaves every other bit unchanged. It reads the new PC from TBR + 0x3FC - 4*num. For num 255, this address is TBR itself.
- R3: An emulator trap clears only PS bit 5 (S) and keeps bit 4 (I) and all other bits. It reads the new PC from TBR + 0x3D8 and ignores the number.
- R4: A return (op 2'b10) reads the new PC from SSP and then reads the whole new PS, including N, Z, V and C in bits 3:0, from SSP+4.
- R5: The stack pointer output ends at SSP-8 after either trap entry and at SSP+8 after a return.
- R6: Each access keeps mem_req_o, address, direction and write data unchanged until mem_ack_i is seen. The block moves to the next access only after the acknowledge.
- R7: busy_o rises in the cycle after start is accepted and stays high through the cycle in which done_o pulses. done_o is high for exactly one cycle.
- R8: A start pulse while busy_o is high has no effect on the accesses or on the results.
- R9: Trap entry makes exactly three accesses (write, write, read). A return makes exactly two reads. No access happens when the block is idle.
- R10: A start with op 2'b11 is ignored: busy_o stays low and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | 00 numbered trap, 01 emulator trap, 10 return, 11 none |
| num_i | input | 8 | Trap number for the numbered trap |
| pc_i | input | 32 | Address of the trap instruction |
| ps_i | input | 32 | Current status word |
| ssp_i | input | 32 | Current system stack pointer |
| tbr_i | input | 32 | Handler table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Data for writes |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes at this clock edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 32 | Resulting program counter |
| ps_o | output | 32 | Resulting status word |
| ssp_o | output | 32 | Resulting system stack pointer |

## Verification
A wrong stack pointer in the sequencer shows up at once as a wrong address on the first or second stacking access. This happens a full access before the final pointer reaches ssp_o, so the scoreboard flags it in the cycle the request first appears. A wrong state shows up as a missing, extra or misordered access, or as busy staying high. The queue of expected accesses catches this within one access, and the bounded wait for done catches it within a few dozen cycles. Flag-clearing errors stay hidden on the bus because the pushed word is the original PS, so they are visible only in ps_o at done. The round trip through entry and return checks this value against what entry stored.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      TK_SOFT   = 2'b00,
      TK_EMU    = 2'b01,
      TK_RETURN = 2'b10,
      TK_NONE   = 2'b11
   } trap_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_PS = 3'd1,
      ST_PUSH_PC = 3'd2,
      ST_VEC     = 3'd3,
      ST_POP_PC  = 3'd4,
      ST_POP_PS  = 3'd5,
      ST_FIN     = 3'd6
   } trap_state_e;

   localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/trap_vec_addr.sv
// Handler table address: counts down from the top of the table for numbered
// traps, fixed slot for the emulator trap.
module trap_vec_addr
   import trap_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned VNUM_W  = 8,
   parameter int unsigned VEC_TOP = 'h3FC,
   parameter int unsigned EMU_VEC = 'h3D8
) (
   input  logic [XLEN-1:0]   tbr,
   input  logic [VNUM_W-1:0] num,
   input  trap_kind_e        kind,
   output logic [XLEN-1:0]   addr
);
   localparam logic [XLEN-1:0] TOP_OFS = XLEN'(VEC_TOP);
   localparam logic [XLEN-1:0] EMU_OFS = XLEN'(EMU_VEC);

   logic [XLEN-1:0] slot_ofs;
   logic [XLEN-1:0] num_bytes;

   always_comb begin
      num_bytes = XLEN'({num, 2'b00});
      slot_ofs  = TOP_OFS - num_bytes;
      if (kind == TK_EMU) begin
         addr = tbr + EMU_OFS;
      end else begin
         addr = tbr + slot_ofs;
      end
   end

endmodule

// File: rtl/trap_ps_mask.sv
// Status-word flag clearing on trap entry; the mask is built bit by bit.
module trap_ps_mask
   import trap_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned S_BIT = 5,
   parameter int unsigned I_BIT = 4
) (
   input  logic [XLEN-1:0] ps_in,
   input  trap_kind_e      kind,
   output logic [XLEN-1:0] ps_out
);
   logic            clear_i;
   logic [XLEN-1:0] clr_mask;

   assign clear_i = (kind == TK_SOFT);

   for (genvar b = 0; b < XLEN; b++) begin : g_mask
      if (b == S_BIT) begin : g_s
         assign clr_mask[b] = 1'b1;
      end else if (b == I_BIT) begin : g_i
         assign clr_mask[b] = clear_i;
      end else begin : g_keep
         assign clr_mask[b] = 1'b0;
      end
   end

   assign ps_out = ps_in & ~clr_mask;

endmodule

// File: rtl/trap_bus_mux.sv
// Selects the address, direction and write data of the current access.
module trap_bus_mux
   import trap_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned PC_STEP = 2
) (
   input  trap_state_e     state,
   input  logic [XLEN-1:0] ssp,
   input  logic [XLEN-1:0] ps,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] vec_addr,
   output logic            req,
   output logic            we,
   output logic [XLEN-1:0] addr,
   output logic [XLEN-1:0] wdata
);
   localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);
   localparam logic [XLEN-1:0] PSTEP = XLEN'(PC_STEP);

   always_comb begin
      req   = 1'b0;
      we    = 1'b0;
      addr  = '0;
      wdata = '0;
      unique case (state)
         ST_PUSH_PS: begin
            req   = 1'b1;
            we    = 1'b1;
            addr  = ssp - WSTEP;
            wdata = ps;
         end
         ST_PUSH_PC: begin
            req   = 1'b1;
            we    = 1'b1;
            addr  = ssp - WSTEP;
            wdata = pc + PSTEP;
         end
         ST_VEC: begin
            req  = 1'b1;
            addr = vec_addr;
         end
         ST_POP_PC, ST_POP_PS: begin
            req  = 1'b1;
            addr = ssp;
         end
         default: begin
            req = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned VNUM_W  = 8,
   parameter int unsigned PC_STEP = 2,
   parameter int unsigned S_BIT   = 5,
   parameter int unsigned I_BIT   = 4,
   parameter int unsigned VEC_TOP = 'h3FC,
   parameter int unsigned EMU_VEC = 'h3D8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [VNUM_W-1:0] num_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   ps_i,
   input  logic [XLEN-1:0]   ssp_i,
   input  logic [XLEN-1:0]   tbr_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [XLEN-1:0]   mem_addr_o,
   output logic [XLEN-1:0]   mem_wdata_o,
   input  logic [XLEN-1:0]   mem_rdata_i,
   input  logic              mem_ack_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   ps_o,
   output logic [XLEN-1:0]   ssp_o
);
   localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);

   // elaboration-time parameter checks
   if (XLEN < 16) begin : g_bad_xlen
      $error("trap_seq: XLEN must be at least 16");
   end
   if (S_BIT == I_BIT || S_BIT >= XLEN || I_BIT >= XLEN) begin : g_bad_bits
      $error("trap_seq: flag bit positions invalid");
   end
   if ((VEC_TOP % WORD_BYTES) != 0 || (EMU_VEC % WORD_BYTES) != 0) begin : g_bad_align
      $error("trap_seq: table offsets must be word aligned");
   end
   if (VEC_TOP < WORD_BYTES * ((1 << VNUM_W) - 1)) begin : g_bad_top
      $error("trap_seq: table top too low for the number range");
   end

   trap_state_e       state_q;
   trap_kind_e        kind_q;
   logic [XLEN-1:0]   ssp_q;
   logic [XLEN-1:0]   ps_q;
   logic [XLEN-1:0]   pc_q;
   logic [XLEN-1:0]   tbr_q;
   logic [VNUM_W-1:0] num_q;

   logic [XLEN-1:0]   vec_addr;
   logic [XLEN-1:0]   ps_cleared;
   logic              accept;
   logic              acked;

   trap_vec_addr #(
      .XLEN    (XLEN),
      .VNUM_W  (VNUM_W),
      .VEC_TOP (VEC_TOP),
      .EMU_VEC (EMU_VEC)
   ) u_vec (
      .tbr  (tbr_q),
      .num  (num_q),
      .kind (kind_q),
      .addr (vec_addr)
   );

   trap_ps_mask #(
      .XLEN  (XLEN),
      .S_BIT (S_BIT),
      .I_BIT (I_BIT)
   ) u_mask (
      .ps_in  (ps_q),
      .kind   (kind_q),
      .ps_out (ps_cleared)
   );

   trap_bus_mux #(
      .XLEN    (XLEN),
      .PC_STEP (PC_STEP)
   ) u_bus (
      .state    (state_q),
      .ssp      (ssp_q),
      .ps       (ps_q),
      .pc       (pc_q),
      .vec_addr (vec_addr),
      .req      (mem_req_o),
      .we       (mem_we_o),
      .addr     (mem_addr_o),
      .wdata    (mem_wdata_o)
   );

   assign accept = start_i && (state_q == ST_IDLE) && (op_i != TK_NONE);
   assign acked  = mem_req_o && mem_ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= TK_NONE;
         ssp_q   <= '0;
         ps_q    <= '0;
         pc_q    <= '0;
         tbr_q   <= '0;
         num_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q  <= trap_kind_e'(op_i);
                  ssp_q   <= ssp_i;
                  ps_q    <= ps_i;
                  pc_q    <= pc_i;
                  tbr_q   <= tbr_i;
                  num_q   <= num_i;
                  state_q <= (op_i == TK_RETURN) ? ST_POP_PC : ST_PUSH_PS;
               end
            end
            ST_PUSH_PS: begin
               if (acked) begin
                  ssp_q   <= ssp_q - WSTEP;
                  state_q <= ST_PUSH_PC;
               end
            end
            ST_PUSH_PC: begin
               if (acked) begin
                  ssp_q   <= ssp_q - WSTEP;
                  ps_q    <= ps_cleared;
                  state_q <= ST_VEC;
               end
            end
            ST_VEC: begin
               if (acked) begin
                  pc_q    <= mem_rdata_i;
                  state_q <= ST_FIN;
               end
            end
            ST_POP_PC: begin
               if (acked) begin
                  pc_q    <= mem_rdata_i;
                  ssp_q   <= ssp_q + WSTEP;
                  state_q <= ST_POP_PS;
               end
            end
            ST_POP_PS: begin
               if (acked) begin
                  ps_q    <= mem_rdata_i;
                  ssp_q   <= ssp_q + WSTEP;
                  state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_FIN);
   assign pc_o   = pc_q;
   assign ps_o   = ps_q;
   assign ssp_o  = ssp_q;

   // R6: a pending access keeps all its attributes until acknowledged
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R7: done is a single-cycle pulse inside the busy window
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R8: busy only ends through done, so a start mid-operation cannot restart it
   p_busy_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R5: each acknowledged push moves the stack pointer down one word
   p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i && mem_we_o) |=> (ssp_o == $past(ssp_o) - WSTEP));

   // R5: each acknowledged pop moves the stack pointer up one word
   p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i && !mem_we_o && kind_q == TK_RETURN)
      |=> (ssp_o == $past(ssp_o) + WSTEP));

   // R9: a return never writes; idle never requests
   p_return_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && kind_q == TK_RETURN) |-> !mem_we_o);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);

   // R2: a numbered trap finishes with S and I clear
   p_soft_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_q == TK_SOFT) |-> (!ps_o[S_BIT] && !ps_o[I_BIT]));

   // R3: an emulator trap finishes with S clear
   p_emu_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_q == TK_EMU) |-> !ps_o[S_BIT]);

   // R10: an op of 11 from idle leaves the block idle
   p_none_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && op_i == 2'b11) |=> !busy_o);

endmodule

// File: tb/trap_seq_tb_top.sv
module trap_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [1:0]  op_i;
   logic [7:0]  num_i;
   logic [31:0] pc_i, ps_i, ssp_i, tbr_i;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        mem_ack_i;
   logic        busy_o, done_o;
   logic [31:0] pc_o, ps_o, ssp_o;

   always #4 clk = ~clk;   // 125 MHz

   trap_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .num_i(num_i),
      .pc_i(pc_i), .ps_i(ps_i), .ssp_i(ssp_i), .tbr_i(tbr_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .ps_o(ps_o), .ssp_o(ssp_o)
   );

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } xact_t;

   xact_t       exp_q[$];
   logic [31:0] mem [logic [31:0]];
   int          n_chk  = 0;
   int          n_fail = 0;
   int          wait_cfg = 0;
   bit          finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // monitor: pops expected accesses and answers them as memory
   initial begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
      forever begin
         @(negedge clk);
         mem_ack_i = 1'b0;
         if (rst_n && mem_req_o) begin
            xact_t e;
            logic [31:0] a;
            a = mem_addr_o;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "access with none expected", a, 32'h0);
            end else begin
               e = exp_q.pop_front();
               check(mem_we_o == e.we, e.tag, "direction", {31'b0, mem_we_o}, {31'b0, e.we});
               check(a == e.addr, e.tag, "address", a, e.addr);
               if (e.we) check(mem_wdata_o == e.data, e.tag, "write data", mem_wdata_o, e.data);
            end
            for (int w = 0; w < wait_cfg; w++) begin
               @(negedge clk);
               check(mem_req_o && mem_addr_o == a, "R6", "request held during wait",
                     mem_addr_o, a);
            end
            if (mem_we_o) mem[a] = mem_wdata_o;
            else mem_rdata_i = mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
            mem_ack_i = 1'b1;
         end
      end
   end

   function automatic xact_t mk(input bit we, input logic [31:0] a,
                                input logic [31:0] d, input string t);
      xact_t x;
      x.we = we; x.addr = a; x.data = d; x.tag = t;
      return x;
   endfunction

   // driver: pushes expected accesses, starts the op, checks the results
   task automatic run_op(input logic [1:0] op, input logic [7:0] num,
                         input logic [31:0] pc, input logic [31:0] ps,
                         input logic [31:0] ssp, input logic [31:0] tbr,
                         input bit poke, input string rq);
      logic [31:0] e_pc, e_ps, e_ssp, va;
      bit seen;
      if (op == 2'b10) begin
         exp_q.push_back(mk(1'b0, ssp, 32'h0, "R4"));
         exp_q.push_back(mk(1'b0, ssp + 32'd4, 32'h0, "R4"));
         e_pc  = mem.exists(ssp) ? mem[ssp] : 32'hDEAD_BEEF;
         e_ps  = mem.exists(ssp + 32'd4) ? mem[ssp + 32'd4] : 32'hDEAD_BEEF;
         e_ssp = ssp + 32'd8;
      end else begin
         va = (op == 2'b01) ? tbr + 32'h3D8 : tbr + 32'h3FC - {22'b0, num, 2'b00};
         exp_q.push_back(mk(1'b1, ssp - 32'd4, ps, "R1"));
         exp_q.push_back(mk(1'b1, ssp - 32'd8, pc + 32'd2, "R1"));
         exp_q.push_back(mk(1'b0, va, 32'h0, (op == 2'b01) ? "R3" : "R2"));
         e_pc  = mem.exists(va) ? mem[va] : 32'hDEAD_BEEF;
         e_ps  = (op == 2'b01) ? (ps & ~32'h20) : (ps & ~32'h30);
         e_ssp = ssp - 32'd8;
      end
      @(negedge clk);
      start_i = 1'b1; op_i = op; num_i = num;
      pc_i = pc; ps_i = ps; ssp_i = ssp; tbr_i = tbr;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R7", "busy after start", {31'b0, busy_o}, 32'h1);
      seen = 0;
      for (int c = 0; c < 60 && !seen; c++) begin
         if (done_o) seen = 1;
         else begin
            if (poke && c == 1) begin
               start_i = 1'b1; op_i = 2'b10; ssp_i = 32'h0000_4000;
            end else begin
               start_i = 1'b0;
            end
            @(negedge clk);
            if (!done_o) check(busy_o, "R7", "busy until done", {31'b0, busy_o}, 32'h1);
         end
      end
      start_i = 1'b0;
      check(seen, rq, "done seen", {31'b0, seen}, 32'h1);
      check(pc_o == e_pc, rq, "pc_o", pc_o, e_pc);
      check(ps_o == e_ps, rq, "ps_o", ps_o, e_ps);
      check(ssp_o == e_ssp, "R5", "ssp_o", ssp_o, e_ssp);
      check(exp_q.size() == 0, "R9", "accesses left", exp_q.size(), 32'h0);
      @(negedge clk);
      check(!done_o, "R7", "done one cycle", {31'b0, done_o}, 32'h0);
      check(!busy_o, "R7", "idle after done", {31'b0, busy_o}, 32'h0);
      exp_q.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R7", "watchdog expired", 32'h0, 32'h1);
      report();
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; num_i = '0;
      pc_i = '0; ps_i = '0; ssp_i = '0; tbr_i = '0;
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !mem_req_o, "R7", "reset idle",
            {29'b0, busy_o, done_o, mem_req_o}, 32'h0);
      rst_n = 1'b1;

      // R2: number 0 uses the top slot
      mem[32'h0001_03FC] = 32'hA000_0100;
      wait_cfg = 0;
      run_op(2'b00, 8'd0, 32'h0000_2000, 32'h0000_003F, 32'h0000_8000,
             32'h0001_0000, 1'b0, "R2");

      // R2: number 255 lands on the table base, with wait states
      mem[32'h0001_0000] = 32'hA000_0200;
      wait_cfg = 2;
      run_op(2'b00, 8'd255, 32'h0000_3000, 32'hFFFF_FFFF, 32'h0000_9000,
             32'h0001_0000, 1'b0, "R2");

      // R2: middle number, only bits 5 and 4 cleared
      mem[32'h0002_03E8] = 32'hA000_0300;
      wait_cfg = 1;
      run_op(2'b00, 8'd5, 32'h0000_4444, 32'h0000_0A35, 32'h0000_7000,
             32'h0002_0000, 1'b0, "R2");

      // R3: emulator trap keeps I, clears S, fixed slot
      mem[32'h0003_03D8] = 32'hB000_0000;
      wait_cfg = 1;
      run_op(2'b01, 8'd9, 32'h0000_5000, 32'h0000_0033, 32'h0000_6000,
             32'h0003_0000, 1'b0, "R3");

      // R4: return restores PC and the whole PS including NZVC
      mem[32'h0000_5000] = 32'h0000_1234;
      mem[32'h0000_5004] = 32'h0000_001A;
      wait_cfg = 0;
      run_op(2'b10, 8'd0, 32'h0, 32'h0, 32'h0000_5000, 32'h0, 1'b0, "R4");

      // R4: round trip, entry then return brings back PC+2 and PS
      mem[32'h0004_03F8] = 32'hC000_0000;
      wait_cfg = 3;
      run_op(2'b00, 8'd1, 32'h0000_7770, 32'h0000_0035, 32'h0000_A000,
             32'h0004_0000, 1'b0, "R2");
      run_op(2'b10, 8'd0, 32'h0, 32'h0, 32'h0000_9FF8, 32'h0, 1'b0, "R4");
      check(pc_o == 32'h0000_7772, "R4", "round trip pc", pc_o, 32'h0000_7772);
      check(ps_o == 32'h0000_0035, "R4", "round trip ps", ps_o, 32'h0000_0035);

      // R8: start pulse while busy does not disturb the run
      mem[32'h0005_03FC] = 32'hD000_0000;
      wait_cfg = 2;
      run_op(2'b00, 8'd0, 32'h0000_1000, 32'h0000_0010, 32'h0000_B000,
             32'h0005_0000, 1'b1, "R8");

      // R10: op 11 is ignored
      @(negedge clk);
      start_i = 1'b1; op_i = 2'b11;
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o, "R10", "op 11 stays idle", {31'b0, busy_o}, 32'h0);
      repeat (3) @(negedge clk);
      check(!busy_o && !mem_req_o, "R10", "no access after op 11",
            {30'b0, busy_o, mem_req_o}, 32'h0);
      check(ssp_o == 32'h0000_AFF8, "R10", "results unchanged", ssp_o, 32'h0000_AFF8);

      report();
   end

endmodule